// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block produces every control line of a multi-cycle 32-bit RISC datapath. The datapath spends several clock cycles on each instruction. The block keeps a step index that counts those cycles. From the step index and the 6-bit opcode held in the instruction register, it works out which multiplexer selections, register loads and memory strobes are active in the current cycle. The datapath, memory, register file and ALU sit outside the block. It sees only the opcode, and it drives the controls back to them.

Every instruction starts with the same two steps:
- a fetch step, which reads the instruction and advances the program counter by four;
- a decode step, which loads the operand registers and always forms the branch target, even when the instruction will never use it.

After these two steps, each instruction class runs its own tail of execute, memory and write-back steps. The length of the tail depends on the class, so the classes take different numbers of cycles. Only the ALU, load, store, branch and jump classes are recognised. Any other opcode goes back to fetch straight after decode. The step index is brought out so that the datapath can observe it.

Top module: `mc_ctrl_unit`

## Requirements
- R1: The reset `rst_n` is active low and synchronous. At the clock edge where `rst_n` is low, `step_idx` becomes 0, and the fetch control set of R2 is driven in the next cycle. This holds even when reset arrives in the middle of an instruction.
- R2: In step 0 the block drives the fetch set: `mem_rd_en`=1, `ir_load`=1, `pc_load`=1, `addr_sel_data`=0, `alu_a_sel`=0, `alu_b_sel`=01 (constant 4), `alu_mode`=00 (add), and `pc_next_sel`=00 (ALU result).
- R3: Step 1 is decode. It drives `alu_a_sel`=0, `alu_b_sel`=11 (immediate shifted left by two) and `alu_mode`=00 (add) for every opcode, and it asserts no memory or register write strobe.
- R4: For the jump opcode 000010, step 1 additionally asserts `pc_load`=1 with `pc_next_sel`=10 (jump target). The next cycle is step 0.
- R5: The ALU opcode 000000 uses four steps. Step 2 drives `alu_a_sel`=1, `alu_b_sel`=00 (register B) and `alu_mode`=10 (function field). Step 3 drives `wb_dst_sel`=1 (rd field), `rf_wr_en`=1 and `wb_data_sel`=0 (ALU output).
- R6: The load opcode 100011 uses five steps:
  - step 2 drives `alu_a_sel`=1, `alu_b_sel`=10 (sign-extended immediate) and `alu_mode`=00;
  - step 3 drives `addr_sel_data`=1 and `mem_rd_en`=1;
  - step 4 drives `wb_dst_sel`=0 (rt field), `rf_wr_en`=1 and `wb_data_sel`=1 (memory data).
- R7: The store opcode 101011 uses four steps. Step 2 computes the address in the same way as for a load. Step 3 drives `addr_sel_data`=1 and `mem_wr_en`=1.
- R8: The branch opcode 000100 uses three steps. Step 2 drives `alu_a_sel`=1, `alu_b_sel`=00, `alu_mode`=01 (subtract), `pc_load_if_zero`=1 and `pc_next_sel`=01 (ALUOut). `pc_load` stays 0 in that step.
- R9: `step_idx` rises by exactly one per cycle until the instruction's last step, then returns to 0. The lengths in steps are: ALU 4, load 5, store 4, branch 3, jump 2.
- R10: Any output that a step does not name is driven to 0 in that step. `mem_rd_en` and `mem_wr_en` are never high together.
- R11: An opcode outside the five listed above runs only steps 0 and 1, which are fetch and decode with no extra controls, and then returns to step 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode | input | 6 | Opcode field of the instruction register |
| step_idx | output | 3 | Step index within the current instruction |
| addr_sel_data | output | 1 | Memory address select: 0 = PC, 1 = ALUOut |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| ir_load | output | 1 | Instruction register load |
| pc_load | output | 1 | Unconditional PC load |
| pc_load_if_zero | output | 1 | PC load qualified by ALU zero |
| pc_next_sel | output | 2 | PC source: 00 ALU result, 01 ALUOut, 10 jump target |
| alu_a_sel | output | 1 | ALU A input: 0 = PC, 1 = register A |
| alu_b_sel | output | 2 | ALU B input: 00 B, 01 const 4, 10 imm, 11 imm<<2 |
| alu_mode | output | 2 | ALU operation: 00 add, 01 subtract, 10 function field |
| wb_dst_sel | output | 1 | Write-back register: 0 = rt, 1 = rd |
| rf_wr_en | output | 1 | Register file write strobe |
| wb_data_sel | output | 1 | Write-back data: 0 = ALUOut, 1 = memory data |

## Verification
The assertions check properties that hold on every cycle:
- the step index moves up by one or wraps to 0;
- a register write is always followed by step 0;
- the instruction register loads only in step 0;
- the two memory strobes never overlap;
- the conditional and unconditional PC loads never overlap;
- any PC load outside fetch takes the jump target.

Some behaviour can only be shown by the bench's scenarios:
- the exact control set of each step for each opcode;
- the step count of each class;
- fall-through of unknown opcodes after decode;
- reset recovery in the middle of an instruction.

// File: rtl/mc_ctrl_pkg.sv
`timescale 1ns/1ps
// Package: mc_ctrl_pkg
// Shared opcodes, encodings, instruction classes and the control word type
// for the multi-cycle control sequencer. Assumes 6-bit opcodes.
package mc_ctrl_pkg;

    localparam int OP_W = 6;

    localparam logic [OP_W-1:0] OPC_ALU    = 6'b000000;
    localparam logic [OP_W-1:0] OPC_LOAD   = 6'b100011;
    localparam logic [OP_W-1:0] OPC_STORE  = 6'b101011;
    localparam logic [OP_W-1:0] OPC_BRANCH = 6'b000100;
    localparam logic [OP_W-1:0] OPC_JUMP   = 6'b000010;

    localparam logic [1:0] BSEL_REG   = 2'b00;
    localparam logic [1:0] BSEL_FOUR  = 2'b01;
    localparam logic [1:0] BSEL_IMM   = 2'b10;
    localparam logic [1:0] BSEL_IMMSH = 2'b11;

    localparam logic [1:0] AMODE_ADD  = 2'b00;
    localparam logic [1:0] AMODE_SUB  = 2'b01;
    localparam logic [1:0] AMODE_FUNC = 2'b10;

    localparam logic [1:0] PSEL_ALU   = 2'b00;
    localparam logic [1:0] PSEL_OUT   = 2'b01;
    localparam logic [1:0] PSEL_JMP   = 2'b10;

    typedef enum logic [2:0] {
        CLS_ALU,
        CLS_LOAD,
        CLS_STORE,
        CLS_BRANCH,
        CLS_JUMP,
        CLS_OTHER
    } instr_cls_e;

    typedef struct packed {
        logic       addr_sel_data;
        logic       mem_rd_en;
        logic       mem_wr_en;
        logic       ir_load;
        logic       pc_load;
        logic       pc_load_if_zero;
        logic [1:0] pc_next_sel;
        logic       alu_a_sel;
        logic [1:0] alu_b_sel;
        logic [1:0] alu_mode;
        logic       wb_dst_sel;
        logic       rf_wr_en;
        logic       wb_data_sel;
    } ctrl_word_t;

    // Number of steps an instruction class occupies, fetch included.
    function automatic int cls_steps(instr_cls_e cls);
        case (cls)
            CLS_ALU:    return 4;
            CLS_LOAD:   return 5;
            CLS_STORE:  return 4;
            CLS_BRANCH: return 3;
            default:    return 2;
        endcase
    endfunction

endpackage

// File: rtl/mc_op_classify.sv
`timescale 1ns/1ps
// Module: mc_op_classify
// Maps the opcode field to an instruction class. Purely combinational.
// Assumes the opcode is stable for the whole instruction after fetch.
module mc_op_classify
    import mc_ctrl_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output instr_cls_e      cls
);

    // Opcode decode into one of the supported classes.
    always_comb begin
        case (opcode)
            OPC_ALU:    cls = CLS_ALU;
            OPC_LOAD:   cls = CLS_LOAD;
            OPC_STORE:  cls = CLS_STORE;
            OPC_BRANCH: cls = CLS_BRANCH;
            OPC_JUMP:   cls = CLS_JUMP;
            default:    cls = CLS_OTHER;
        endcase
    end

endmodule

// File: rtl/mc_step_counter.sv
`timescale 1ns/1ps
// Module: mc_step_counter
// Counts the step within the current instruction and wraps to 0 after the
// last step of the class. Assumes every class has at least two steps, so
// step 0 always advances regardless of the stale opcode during fetch.
module mc_step_counter
    import mc_ctrl_pkg::*;
#(
    parameter int STEP_W = 3
)(
    input  logic              clk,
    input  logic              rst_n,
    input  instr_cls_e        cls,
    output logic [STEP_W-1:0] step
);

    localparam logic [STEP_W-1:0] STEP_ZERO = '0;

    logic [STEP_W-1:0] step_q;
    logic [STEP_W-1:0] last_step;

    // Index of the final step of the current class.
    always_comb last_step = STEP_W'(cls_steps(cls) - 1);

    // Step register: synchronous reset to fetch, wrap after the last step.
    always_ff @(posedge clk) begin
        if (!rst_n)                step_q <= STEP_ZERO;
        else if (step_q >= last_step) step_q <= STEP_ZERO;
        else                       step_q <= step_q + 1'b1;
    end

    assign step = step_q;

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q != STEP_ZERO) |-> (step_q == $past(step_q) + 1'b1)); // R9

endmodule

// File: rtl/mc_ctrl_rom.sv
`timescale 1ns/1ps
// Module: mc_ctrl_rom
// Combinational control table: (class, step) -> control word. Steps 0 and 1
// are shared by every class; later steps depend on the class. Anything not
// named in a step is driven to 0.
module mc_ctrl_rom
    import mc_ctrl_pkg::*;
#(
    parameter int STEP_W = 3
)(
    input  logic              clk,
    input  logic              rst_n,
    input  instr_cls_e        cls,
    input  logic [STEP_W-1:0] step,
    output ctrl_word_t        cw
);

    // Control word generation for the current class and step.
    always_comb begin
        cw = '0;
        case (int'(step))
            0: begin
                cw.mem_rd_en   = 1'b1;
                cw.ir_load     = 1'b1;
                cw.pc_load     = 1'b1;
                cw.alu_b_sel   = BSEL_FOUR;
                cw.alu_mode    = AMODE_ADD;
                cw.pc_next_sel = PSEL_ALU;
            end
            1: begin
                cw.alu_b_sel = BSEL_IMMSH;
                cw.alu_mode  = AMODE_ADD;
                if (cls == CLS_JUMP) begin
                    cw.pc_load     = 1'b1;
                    cw.pc_next_sel = PSEL_JMP;
                end
            end
            2: begin
                case (cls)
                    CLS_ALU: begin
                        cw.alu_a_sel = 1'b1;
                        cw.alu_b_sel = BSEL_REG;
                        cw.alu_mode  = AMODE_FUNC;
                    end
                    CLS_LOAD, CLS_STORE: begin
                        cw.alu_a_sel = 1'b1;
                        cw.alu_b_sel = BSEL_IMM;
                        cw.alu_mode  = AMODE_ADD;
                    end
                    CLS_BRANCH: begin
                        cw.alu_a_sel       = 1'b1;
                        cw.alu_b_sel       = BSEL_REG;
                        cw.alu_mode        = AMODE_SUB;
                        cw.pc_load_if_zero = 1'b1;
                        cw.pc_next_sel     = PSEL_OUT;
                    end
                    default: cw = '0;
                endcase
            end
            3: begin
                case (cls)
                    CLS_ALU: begin
                        cw.wb_dst_sel  = 1'b1;
                        cw.rf_wr_en    = 1'b1;
                        cw.wb_data_sel = 1'b0;
                    end
                    CLS_LOAD: begin
                        cw.addr_sel_data = 1'b1;
                        cw.mem_rd_en     = 1'b1;
                    end
                    CLS_STORE: begin
                        cw.addr_sel_data = 1'b1;
                        cw.mem_wr_en     = 1'b1;
                    end
                    default: cw = '0;
                endcase
            end
            4: begin
                if (cls == CLS_LOAD) begin
                    cw.wb_dst_sel  = 1'b0;
                    cw.rf_wr_en    = 1'b1;
                    cw.wb_data_sel = 1'b1;
                end
            end
            default: cw = '0;
        endcase
    end

    AST_SINGLE_MEM_OP: assert property (@(posedge clk) disable iff (!rst_n)
        !(cw.mem_rd_en && cw.mem_wr_en)); // R10

endmodule

// File: rtl/mc_ctrl_unit.sv
`timescale 1ns/1ps
// Module: mc_ctrl_unit
// Top of the multi-cycle control sequencer. Classifies the opcode, counts
// steps and drives the datapath control lines for the current step.
// Assumes the datapath loads the opcode into its instruction register at
// the end of step 0 and keeps it stable until the next fetch.
module mc_ctrl_unit
    import mc_ctrl_pkg::*;
#(
    parameter int STEP_W = 3
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [5:0]        opcode,
    output logic [STEP_W-1:0] step_idx,
    output logic              addr_sel_data,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic              ir_load,
    output logic              pc_load,
    output logic              pc_load_if_zero,
    output logic [1:0]        pc_next_sel,
    output logic              alu_a_sel,
    output logic [1:0]        alu_b_sel,
    output logic [1:0]        alu_mode,
    output logic              wb_dst_sel,
    output logic              rf_wr_en,
    output logic              wb_data_sel
);

    instr_cls_e        cls;
    logic [STEP_W-1:0] step;
    ctrl_word_t        cw;

    mc_op_classify u_classify (
        .opcode (opcode),
        .cls    (cls)
    );

    mc_step_counter #(.STEP_W(STEP_W)) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .cls   (cls),
        .step  (step)
    );

    mc_ctrl_rom #(.STEP_W(STEP_W)) u_rom (
        .clk   (clk),
        .rst_n (rst_n),
        .cls   (cls),
        .step  (step),
        .cw    (cw)
    );

    // Unpack the control word onto the ports.
    always_comb begin
        step_idx        = step;
        addr_sel_data   = cw.addr_sel_data;
        mem_rd_en       = cw.mem_rd_en;
        mem_wr_en       = cw.mem_wr_en;
        ir_load         = cw.ir_load;
        pc_load         = cw.pc_load;
        pc_load_if_zero = cw.pc_load_if_zero;
        pc_next_sel     = cw.pc_next_sel;
        alu_a_sel       = cw.alu_a_sel;
        alu_b_sel       = cw.alu_b_sel;
        alu_mode        = cw.alu_mode;
        wb_dst_sel      = cw.wb_dst_sel;
        rf_wr_en        = cw.rf_wr_en;
        wb_data_sel     = cw.wb_data_sel;
    end

    AST_IR_ONLY_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        ir_load |-> (step_idx == '0)); // R2

    AST_WB_ENDS_INSTR: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |=> (step_idx == '0)); // R9

    AST_PC_LOAD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_if_zero |-> !pc_load); // R8

    AST_LATE_PC_IS_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && (step_idx != '0)) |-> (pc_next_sel == PSEL_JMP)); // R4

endmodule

// File: tb/mc_ctrl_unit_test.sv
`timescale 1ns/1ps
// Scoreboard bench: a driver task pushes the expected step vector of each
// cycle into a queue; a monitor pops and compares at every falling edge.
module mc_ctrl_unit_test;

    localparam int WATCHDOG = 5000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [5:0] opcode;
    logic [2:0] step_idx;
    logic       addr_sel_data, mem_rd_en, mem_wr_en, ir_load, pc_load;
    logic       pc_load_if_zero, alu_a_sel, wb_dst_sel, rf_wr_en, wb_data_sel;
    logic [1:0] pc_next_sel, alu_b_sel, alu_mode;

    int n_chk  = 0;
    int n_fail = 0;
    logic [18:0] exp_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    mc_ctrl_unit uut (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .step_idx(step_idx),
        .addr_sel_data(addr_sel_data), .mem_rd_en(mem_rd_en),
        .mem_wr_en(mem_wr_en), .ir_load(ir_load), .pc_load(pc_load),
        .pc_load_if_zero(pc_load_if_zero), .pc_next_sel(pc_next_sel),
        .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_mode(alu_mode),
        .wb_dst_sel(wb_dst_sel), .rf_wr_en(rf_wr_en), .wb_data_sel(wb_data_sel)
    );

    function automatic logic [18:0] observed();
        return {step_idx, addr_sel_data, mem_rd_en, mem_wr_en, ir_load,
                pc_load, pc_load_if_zero, pc_next_sel, alu_a_sel, alu_b_sel,
                alu_mode, wb_dst_sel, rf_wr_en, wb_data_sel};
    endfunction

    // Build a vector in the same field order as observed().
    function automatic logic [18:0] vec(input logic [2:0] st, input logic ad,
        input logic rd, input logic wr, input logic ir, input logic pl,
        input logic pz, input logic [1:0] ps, input logic a,
        input logic [1:0] b, input logic [1:0] m, input logic dst,
        input logic rfw, input logic wbd);
        return {st, ad, rd, wr, ir, pl, pz, ps, a, b, m, dst, rfw, wbd};
    endfunction

    // Expected step count per opcode (R9, R11).
    function automatic int n_steps(input logic [5:0] op);
        case (op)
            6'b000000: return 4;
            6'b100011: return 5;
            6'b101011: return 4;
            6'b000100: return 3;
            default:   return 2;
        endcase
    endfunction

    // Expected control vector for step k of opcode op, from the requirements.
    function automatic logic [18:0] expect_vec(input logic [5:0] op, input int k);
        logic [2:0] s;
        s = 3'(k);
        if (k == 0) return vec(s,0,1,0,1,1,0,2'b00,0,2'b01,2'b00,0,0,0);      // R2
        if (k == 1) begin
            if (op == 6'b000010)
                return vec(s,0,0,0,0,1,0,2'b10,0,2'b11,2'b00,0,0,0);          // R4
            return vec(s,0,0,0,0,0,0,2'b00,0,2'b11,2'b00,0,0,0);              // R3
        end
        case (op)
            6'b000000:
                if (k == 2) return vec(s,0,0,0,0,0,0,2'b00,1,2'b00,2'b10,0,0,0); // R5
                else        return vec(s,0,0,0,0,0,0,2'b00,0,2'b00,2'b00,1,1,0);
            6'b100011:
                if (k == 2)      return vec(s,0,0,0,0,0,0,2'b00,1,2'b10,2'b00,0,0,0); // R6
                else if (k == 3) return vec(s,1,1,0,0,0,0,2'b00,0,2'b00,2'b00,0,0,0);
                else             return vec(s,0,0,0,0,0,0,2'b00,0,2'b00,2'b00,0,1,1);
            6'b101011:
                if (k == 2) return vec(s,0,0,0,0,0,0,2'b00,1,2'b10,2'b00,0,0,0); // R7
                else        return vec(s,1,0,1,0,0,0,2'b00,0,2'b00,2'b00,0,0,0);
            default:
                return vec(s,0,0,0,0,0,1,2'b01,1,2'b00,2'b01,0,0,0);            // R8
        endcase
    endfunction

    // Driver: entered just after the edge that begins step 0; leaves at the
    // same point of the next instruction's step 0.
    task automatic run_instr(input logic [5:0] op, input string tag);
        opcode = op;
        for (int k = 0; k < n_steps(op); k++) begin
            exp_q.push_back(expect_vec(op, k));
            tag_q.push_back(tag);
            @(posedge clk); #1;
        end
    endtask

    task automatic check_now(input string tag, input logic [18:0] e);
        logic [18:0] got;
        got = observed();
        n_chk++;
        if (got !== e) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, e);
        end
    endtask

    // Monitor: compare outputs with the queued expectation mid-cycle.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [18:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check_now(t, e);
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R9 watchdog expired: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n  = 1'b0;
        opcode = 6'b000000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_now("R1 reset state", vec(3'd0,0,1,0,1,1,0,2'b00,0,2'b01,2'b00,0,0,0));
        @(posedge clk); #1;
        rst_n = 1'b1;

        run_instr(6'b000000, "R2/R3/R5/R9/R10 alu");
        run_instr(6'b100011, "R2/R3/R6/R9/R10 load");
        run_instr(6'b101011, "R2/R3/R7/R9/R10 store");
        run_instr(6'b000100, "R2/R3/R8/R9/R10 branch");
        run_instr(6'b000010, "R4/R9 jump");
        run_instr(6'b111111, "R11 unknown 3f");
        run_instr(6'b000001, "R11 unknown 01");
        run_instr(6'b100011, "R6/R9 load back-to-back");
        run_instr(6'b100011, "R6/R9 load back-to-back");
        run_instr(6'b000010, "R4 jump then alu");
        run_instr(6'b000000, "R5 alu after jump");

        // R1: reset arriving in step 2 of a load returns to fetch.
        opcode = 6'b100011;
        @(posedge clk); #1;
        @(posedge clk); #1;
        @(negedge clk);
        check_now("R1 pre-reset step 2", vec(3'd2,0,0,0,0,0,0,2'b00,1,2'b10,2'b00,0,0,0));
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check_now("R1 mid-instruction reset", vec(3'd0,0,1,0,1,1,0,2'b00,0,2'b01,2'b00,0,0,0));
        @(posedge clk); #1;
        rst_n = 1'b1;

        run_instr(6'b101011, "R1/R7 store after reset");
        run_instr(6'b000100, "R8 branch final");

        wait (exp_q.size() == 0);
        @(negedge clk); #1;
        $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
        $finish;
    end

endmodule